// File: doc/BRIEF.md
# Aspect Code Register Slave on a Two-Wire Bus

This block is a standard-mode I2C target that runs from a system clock much faster than the bus clock. It samples SCL and SDA through synchronizers, finds start and stop conditions and bit edges, and gives a host three writable setting bytes and two readable status bytes. The setting bytes drive a 14-bit code that is inserted into the video signal and five control bits. The status bytes return a 14-bit decoded code together with a check-passed flag and a validity flag.

A write names the device, then gives a subaddress that selects the first setting byte to load. Each later data byte goes to the next index. Bytes before the selected index keep their values. A read carries no subaddress and always begins at status byte 0, whatever index an earlier write left behind. SDA is open-drain: the block only ever pulls it low, through `sda_oe`.

Top module: `aspect_i2c_slave`

## Requirements
- R1: During and after reset, `ins_code` and all five control outputs are 0 and `sda_oe` is 0.
- R2: The block ACKs (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal DEV_ADDR (default 7'h20, write byte 8'h40). Any other address gets no ACK, and the bytes that follow it change no output.
- R3: Setting byte 0 maps bits [7:6] to `ins_code[13:12]` and bits [3:0] to `ins_code[11:8]`; bits [5:4] are dropped. Setting byte 1 maps to `ins_code[7:0]`. A write with subaddress 0 loads bytes 0, 1 and 2 in that order.
- R4: Setting byte 2 maps bit 7 to `chan_sel`, bit 6 to `core_reset`, bit 5 to `ins_en`, bit 4 to `test_mode` and bit 3 to `line_narrow`; bits [2:0] are dropped. A write that starts at subaddress 2 leaves `ins_code` unchanged, and code and control outputs never change in the same cycle.
- R5: The first byte after the address is the subaddress, and the index then rises by one per data byte. Data bytes at index 3 or higher are ACKed and discarded.
- R6: A read returns status byte 0 = {`stat_code[13:12]`, `stat_crc_ok`, `stat_valid`, `stat_code[11:8]`}, then status byte 1 = `stat_code[7:0]`, MSB first. It starts at byte 0 even right after a write.
- R7: Read bytes past status byte 1 are 8'hFF. After the host NACKs a read byte, `sda_oe` stays 0 until the next start.
- R8: `sda_oe` and all setting outputs change only while SCL is low.
- R9: A repeated start ends the current transfer and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low |
| stat_code | input | 14 | Decoded code to report |
| stat_crc_ok | input | 1 | Decoded check passed |
| stat_valid | input | 1 | Decoded data judged valid |
| ins_code | output | 14 | Code to insert |
| chan_sel | output | 1 | Decode channel select |
| core_reset | output | 1 | Reset request for the video core |
| ins_en | output | 1 | Insertion enable |
| test_mode | output | 1 | Test control bit |
| line_narrow | output | 1 | Restrict decode to the nominal lines |

## Verification
The bench builds the block with its defaults: DEV_ADDR 7'h20 and two synchronizer stages. It drives the bus at eight system clocks per quarter bit. That leaves sixteen cycles of SCL low, so the three-cycle path from a bus edge to `sda_oe` completes inside every low phase. This setup reaches subaddresses 0 to 3 and the discard path past index 2. It also covers a wrong address, a read that wraps past the status bytes, and a read after a repeated start that follows a write.

// File: rtl/aspect_i2c_slave.sv
module aspect_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [13:0] stat_code,
  input  logic        stat_crc_ok,
  input  logic        stat_valid,
  output logic [13:0] ins_code,
  output logic        chan_sel,
  output logic        core_reset,
  output logic        ins_en,
  output logic        test_mode,
  output logic        line_narrow
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [7:0] IDX_MAX  = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WR, S_RD} st_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;
  st_t  st;
  logic [3:0] cnt;
  logic       in_ack, rw, mnack;
  logic [7:0] shreg, ptr;
  logic [7:0] rd0, rd1, rd_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  wire scl_s   = scl_sync[SYNC_STAGES-1];
  wire sda_s   = sda_sync[SYNC_STAGES-1];
  wire scl_r   = scl_s & ~scl_d;
  wire scl_f   = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;

  assign rd0 = {stat_code[13:12], stat_crc_ok, stat_valid, stat_code[11:8]};
  assign rd1 = stat_code[7:0];
  assign rd_nx = (ptr == 8'd0) ? rd1 : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      in_ack      <= 1'b0;
      rw          <= 1'b0;
      mnack       <= 1'b0;
      shreg       <= '0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      ins_code    <= '0;
      chan_sel    <= 1'b0;
      core_reset  <= 1'b0;
      ins_en      <= 1'b0;
      test_mode   <= 1'b0;
      line_narrow <= 1'b0;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_r) begin
        if (in_ack) begin
          if (st == S_RD) mnack <= sda_s;
        end else if (cnt != LAST_BIT) begin
          if (st != S_RD) shreg <= {shreg[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
      end else if (scl_f) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (st)
            S_ADDR: begin
              if (rw) begin
                st     <= S_RD;
                ptr    <= '0;
                shreg  <= rd0;
                sda_oe <= ~rd0[7];
              end else begin
                st <= S_SUB;
              end
            end
            S_SUB: st <= S_WR;
            S_WR:  if (ptr != IDX_MAX) ptr <= ptr + 8'd1;
            S_RD: begin
              if (mnack) begin
                st <= S_IDLE;
              end else begin
                shreg  <= rd_nx;
                sda_oe <= ~rd_nx[7];
                if (ptr != IDX_MAX) ptr <= ptr + 8'd1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end else if (cnt == LAST_BIT) begin
          in_ack <= 1'b1;
          case (st)
            S_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
              end else begin
                st     <= S_IDLE;
                in_ack <= 1'b0;
              end
            end
            S_SUB: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
            end
            S_WR: begin
              sda_oe <= 1'b1;
              case (ptr)
                8'd0: begin
                  ins_code[13:12] <= shreg[7:6];
                  ins_code[11:8]  <= shreg[3:0];
                end
                8'd1: ins_code[7:0] <= shreg;
                8'd2: begin
                  chan_sel    <= shreg[7];
                  core_reset  <= shreg[6];
                  ins_en      <= shreg[5];
                  test_mode   <= shreg[4];
                  line_narrow <= shreg[3];
                end
                default: ;
              endcase
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (st == S_RD) begin
          sda_oe <= ~shreg[3'd7 - cnt[2:0]];
        end
      end
    end
  end

endmodule

module aspect_i2c_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [13:0] ins_code,
  input logic        chan_sel,
  input logic        core_reset,
  input logic        ins_en,
  input logic        test_mode,
  input logic        line_narrow
);
  wire [4:0] ctrl = {chan_sel, core_reset, ins_en, test_mode, line_narrow};

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (ins_code == '0 && ctrl == '0 && !sda_oe); // R1
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R8

  AST_CODE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ins_code) |-> !scl_i); // R3

  AST_CTRL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> !scl_i); // R8

  AST_ONE_BYTE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $stable(ins_code)); // R4
endmodule

bind aspect_i2c_slave aspect_i2c_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .ins_code(ins_code), .chan_sel(chan_sel), .core_reset(core_reset),
  .ins_en(ins_en), .test_mode(test_mode), .line_narrow(line_narrow)
);

// File: tb/aspect_i2c_slave_tb.sv
module aspect_i2c_slave_tb_top;
  localparam int Q = 8;
  localparam int NV = 6;
  // {sub[52:45], count[44:43], d0, d1, d2, expected code[18:5], expected ctrl[4:0]}
  localparam logic [52:0] VEC [NV] = '{
    {8'h00, 2'd3, 8'hA5, 8'h3C, 8'hF8, 14'h253C, 5'b11111},
    {8'h02, 2'd1, 8'h40, 8'h00, 8'h00, 14'h253C, 5'b01000},
    {8'h00, 2'd1, 8'h0F, 8'h00, 8'h00, 14'h0F3C, 5'b01000},
    {8'h01, 2'd2, 8'hC3, 8'h88, 8'h00, 14'h0FC3, 5'b10001},
    {8'h03, 2'd1, 8'hFF, 8'h00, 8'h00, 14'h0FC3, 5'b10001},
    {8'h02, 2'd2, 8'h18, 8'hAA, 8'h00, 14'h0FC3, 5'b00011}
  };

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_oe;
  logic [13:0] stat_code = '0;
  logic stat_crc_ok = 0, stat_valid = 0;
  logic [13:0] ins_code;
  logic chan_sel, core_reset, ins_en, test_mode, line_narrow;
  int checks = 0, failures = 0;
  bit done = 0;

  wire sda = m_sda & ~sda_oe;
  wire [4:0] ctrl = {chan_sel, core_reset, ins_en, test_mode, line_narrow};

  always #10 clk = ~clk;

  aspect_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda), .sda_oe(sda_oe),
    .stat_code(stat_code), .stat_crc_ok(stat_crc_ok), .stat_valid(stat_valid),
    .ins_code(ins_code), .chan_sel(chan_sel), .core_reset(core_reset),
    .ins_en(ins_en), .test_mode(test_mode), .line_narrow(line_narrow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; qw(Q); m_scl = 1; qw(Q); m_sda = 0; qw(Q); m_scl = 0; qw(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; qw(Q); m_scl = 1; qw(Q); m_sda = 1; qw(Q);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw(Q); m_scl = 1; qw(2*Q); m_scl = 0; qw(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda = 1; qw(Q); m_scl = 1; qw(Q); b = sda; qw(Q); m_scl = 0; qw(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    qw(5);
    chk("R1 code at reset", 32'(ins_code), 0);
    chk("R1 ctrl/oe at reset", {26'd0, ctrl, sda_oe}, 0);
    rst_n = 1;
    qw(5);
    chk("R1 after release", {ins_code, ctrl, sda_oe}, 0);

    for (int v = 0; v < NV; v++) begin
      bus_start;
      wbyte(8'h40, ack);
      chk("R2 address ack", 32'(ack), 1);
      wbyte(VEC[v][52:45], ack);
      chk("R5 subaddress ack", 32'(ack), 1);
      for (int k = 0; k < int'(VEC[v][44:43]); k++) begin
        wbyte(VEC[v][42 - 8*k -: 8], ack);
        chk("R5 data ack", 32'(ack), 1);
      end
      bus_stop;
      qw(4);
      chk("R3 code after write", 32'(ins_code), 32'(VEC[v][18:5]));
      chk("R4 ctrl after write", 32'(ctrl), 32'(VEC[v][4:0]));
    end

    // R2: foreign address
    bus_start;
    wbyte(8'h42, ack);
    chk("R2 foreign address no ack", 32'(ack), 0);
    wbyte(8'h00, ack);
    wbyte(8'h55, ack);
    bus_stop;
    qw(4);
    chk("R2 code unchanged", 32'(ins_code), 32'h0FC3);
    chk("R2 ctrl unchanged", 32'(ctrl), 32'b00011);

    // R6 / R7 read with wrap past status bytes
    stat_code = 14'h2A5C; stat_crc_ok = 1; stat_valid = 0;
    bus_start;
    wbyte(8'h41, ack);
    chk("R2 read address ack", 32'(ack), 1);
    rbyte(rb, 1);
    chk("R6 status byte 0", 32'(rb), 32'hAA);
    rbyte(rb, 1);
    chk("R6 status byte 1", 32'(rb), 32'h5C);
    rbyte(rb, 0);
    chk("R7 byte past end", 32'(rb), 32'hFF);
    qw(3*Q);
    chk("R7 released after nack", 32'(sda_oe), 0);
    bus_stop;

    // R9 / R6: write leaves index at 3, repeated start read begins at byte 0
    stat_code = 14'h1234; stat_crc_ok = 0; stat_valid = 1;
    bus_start;
    wbyte(8'h40, ack);
    wbyte(8'h02, ack);
    wbyte(8'hE0, ack);
    bus_start;
    wbyte(8'h41, ack);
    chk("R9 repeated start address ack", 32'(ack), 1);
    rbyte(rb, 1);
    chk("R6 read restarts at byte 0", 32'(rb), 32'h52);
    rbyte(rb, 0);
    chk("R6 second status byte", 32'(rb), 32'h34);
    bus_stop;
    qw(4);
    chk("R4 ctrl from byte 2", 32'(ctrl), 32'b11100);
    chk("R4 code untouched", 32'(ins_code), 32'h0FC3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule